// File: doc/BRIEF.md
# Packed Element Insert Unit

This datapath block places one scalar value into a copy of a 128-bit vector and returns the result as a 256-bit register image. The upper 128 bits of that image are always zero. Integer inserts can write a byte, a 16-bit word, a 32-bit word or a 64-bit word. The position comes from an 8-bit index, and only the bits needed for the element count of that size are used. The scalar is cut down to the element width.

A second mode inserts a single-precision element. One 8-bit control selects three things: a source element from a second vector, a destination slot, and a mask that zeroes result elements after the insertion. In memory form the source element is the low 32 bits of the scalar input instead.

The block has no handshake. Each valid request produces a registered result one cycle later. Address generation and memory reads happen upstream.

Top module: `vec_insert_unit`

## Requirements
- R1: With `in_fp`=0 and `in_size`=0 (byte), byte number `in_ctrl & 0xF` of `in_base` is replaced by `in_scalar[7:0]`. Byte k occupies bits 8k+7:8k.
- R2: With `in_fp`=0 and `in_size`=1 (16-bit), element `in_ctrl & 0x7` is replaced by `in_scalar[15:0]`.
- R3: With `in_fp`=0 and `in_size`=2 (32-bit), element `in_ctrl & 0x3` is replaced by `in_scalar[31:0]`.
- R4: With `in_fp`=0 and `in_size`=3 (64-bit), element `in_ctrl & 0x1` is replaced by `in_scalar[63:0]`.
- R5: An integer insert leaves every bit of `in_base` outside the selected element unchanged. `in_mem` has no effect on integer inserts.
- R6: With `in_fp`=1 and `in_mem`=0, 32-bit element `in_ctrl[7:6]` of `in_vec2` is written into 32-bit slot `in_ctrl[5:4]` of `in_base`.
- R7: With `in_fp`=1 and `in_mem`=1, the inserted value is `in_scalar[31:0]` and `in_ctrl[7:6]` has no effect.
- R8: In float mode, each set bit k of `in_ctrl[3:0]` zeroes 32-bit element k of the result. The zeroing is applied after the insertion, so it can clear the slot that was just written.
- R9: Bits 255:128 of `out_dst` are always zero.
- R10: `out_valid` equals `in_valid` delayed by one clock. `out_dst` takes the result of a request one clock after it and keeps its value in cycles where `in_valid` is low.
- R11: After a synchronous active-low reset, `out_valid`=0 and `out_dst`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_fp | input | 1 | 0 = integer insert, 1 = single-precision insert |
| in_mem | input | 1 | Float source: 0 = element of `in_vec2`, 1 = `in_scalar[31:0]` |
| in_size | input | 2 | Integer element size: 0 byte, 1 16-bit, 2 32-bit, 3 64-bit |
| in_ctrl | input | 8 | Integer index, or float control (src 7:6, slot 5:4, zero mask 3:0) |
| in_base | input | 128 | Vector that receives the insert |
| in_vec2 | input | 128 | Second vector for the float register form |
| in_scalar | input | 64 | Scalar value to insert |
| out_valid | output | 1 | Result strobe |
| out_dst | output | 256 | Destination image |

## Verification
The base vector has a different value in every byte, and the second vector has a different value in every 32-bit element. This makes any wrong position or wrong source element visible in the output.

Integer cases use each element size, with indices both inside and above the element count. The out-of-range indices show whether the index is masked or misused.

Float cases use several source, slot and mask combinations. A mask that covers the slot just written shows the order of insertion and zeroing. A pair of memory-form requests that differ only in the source field shows that the field is ignored.

Directed cases check the following:
- an all-ones base with a zero scalar, to confirm the untouched bits are kept;
- the output hold when no request is given;
- the reset state.

// File: rtl/vins_pkg.sv
// Shared types for the packed element insert unit.
// Assumes the element size code is used unchanged as a log2 byte count.
package vins_pkg;
    typedef enum logic [1:0] {
        ESZ_BYTE  = 2'd0,
        ESZ_WORD  = 2'd1,
        ESZ_DWORD = 2'd2,
        ESZ_QWORD = 2'd3
    } elem_size_e;
endpackage

// File: rtl/vins_int_merge.sv
// Integer element merge: overwrites one element of the base vector with the
// low bits of the scalar. The element width is 2**size lanes, and the index
// is the control masked to the element count. Assumes that the scalar holds
// at least one element of the largest size.
module vins_int_merge
    import vins_pkg::*;
#(
    parameter int VEC_W  = 128,
    parameter int SCL_W  = 64,
    parameter int LANE_W = 8,
    parameter int CTRL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  elem_size_e        size,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic [VEC_W-1:0]  base,
    input  logic [SCL_W-1:0]  scalar,
    output logic [VEC_W-1:0]  res
);
    localparam int NLANE  = VEC_W / LANE_W;
    localparam int LIDX_W = $clog2(NLANE);
    localparam int SLANE  = SCL_W / LANE_W;
    localparam int SOFF_W = $clog2(SLANE);

    logic [LIDX_W-1:0] elem_idx;
    logic [LANE_W-1:0] scl_lane [SLANE];
    logic [NLANE-1:0]  lane_changed;

    // Index limited to the number of elements of the chosen size.
    always_comb begin
        elem_idx = ctrl[LIDX_W-1:0] & ({LIDX_W{1'b1}} >> size);
    end

    for (genvar s = 0; s < SLANE; s++) begin : g_scl
        assign scl_lane[s] = scalar[s*LANE_W +: LANE_W];
    end

    for (genvar j = 0; j < NLANE; j++) begin : g_lane
        localparam logic [LIDX_W-1:0] JV = LIDX_W'(j);
        logic [LIDX_W-1:0] elem_of_lane;
        logic [LIDX_W-1:0] off_in_elem;

        // Find which element this lane belongs to and its offset inside it.
        always_comb begin
            elem_of_lane = JV >> size;
            off_in_elem  = JV & ~({LIDX_W{1'b1}} << size);
        end

        // The lane takes a scalar lane when its element is selected.
        always_comb begin
            if (elem_of_lane == elem_idx)
                res[j*LANE_W +: LANE_W] = scl_lane[off_in_elem[SOFF_W-1:0]];
            else
                res[j*LANE_W +: LANE_W] = base[j*LANE_W +: LANE_W];
        end

        assign lane_changed[j] = (res[j*LANE_W +: LANE_W] != base[j*LANE_W +: LANE_W]);
    end

    // R5: only the lanes of a single element may differ from the base.
    p_one_element_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(lane_changed) <= (1 << size));
endmodule

// File: rtl/vins_fp_merge.sv
// Single-precision merge. The control picks a source element, a destination
// slot and a zero mask, and the zeroing is applied after the insertion.
// Control layout: zero mask in the low NELEM bits, slot above it, source on top.
module vins_fp_merge #(
    parameter int VEC_W  = 128,
    parameter int ELEM_W = 32,
    localparam int NELEM  = VEC_W / ELEM_W,
    localparam int SEL_W  = $clog2(NELEM),
    localparam int CTRL_W = NELEM + 2*SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              from_mem,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic [VEC_W-1:0]  base,
    input  logic [VEC_W-1:0]  vec2,
    input  logic [ELEM_W-1:0] scalar,
    output logic [VEC_W-1:0]  res
);
    logic [NELEM-1:0]  zmask;
    logic [SEL_W-1:0]  dst_slot;
    logic [SEL_W-1:0]  src_sel;
    logic [ELEM_W-1:0] v2_elem [NELEM];
    logic [ELEM_W-1:0] picked;
    logic [NELEM-1:0]  elem_changed;

    // Split the control byte into its three fields.
    always_comb begin
        zmask    = ctrl[NELEM-1:0];
        dst_slot = ctrl[NELEM +: SEL_W];
        src_sel  = ctrl[NELEM+SEL_W +: SEL_W];
    end

    for (genvar e = 0; e < NELEM; e++) begin : g_v2
        assign v2_elem[e] = vec2[e*ELEM_W +: ELEM_W];
    end

    // Take the value to insert from memory or from the second vector.
    always_comb begin
        picked = from_mem ? scalar : v2_elem[src_sel];
    end

    for (genvar k = 0; k < NELEM; k++) begin : g_elem
        localparam logic [SEL_W-1:0] KV = SEL_W'(k);
        logic [ELEM_W-1:0] inserted;

        // Insert first, then apply the zero mask.
        always_comb begin
            inserted = (KV == dst_slot) ? picked : base[k*ELEM_W +: ELEM_W];
            res[k*ELEM_W +: ELEM_W] = zmask[k] ? '0 : inserted;
        end

        assign elem_changed[k] = (res[k*ELEM_W +: ELEM_W] != base[k*ELEM_W +: ELEM_W]);
    end

    // R6: at most the written slot plus the masked elements may change.
    p_limited_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(elem_changed) <= 1 + $countones(zmask));
endmodule

// File: rtl/vec_insert_unit.sv
// Packed element insert unit, top level. Chooses the integer or float merge
// result, registers it with one cycle of latency, and returns it zero-extended
// to twice the vector width. Assumes a synchronous active-low reset.
module vec_insert_unit
    import vins_pkg::*;
#(
    parameter int VEC_W  = 128,
    parameter int SCL_W  = 64,
    parameter int CTRL_W = 8,
    localparam int OUT_W = 2 * VEC_W,
    localparam int FP_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_fp,
    input  logic              in_mem,
    input  logic [1:0]        in_size,
    input  logic [CTRL_W-1:0] in_ctrl,
    input  logic [VEC_W-1:0]  in_base,
    input  logic [VEC_W-1:0]  in_vec2,
    input  logic [SCL_W-1:0]  in_scalar,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_dst
);
    localparam int NFP = VEC_W / FP_W;

    logic [VEC_W-1:0] int_res;
    logic [VEC_W-1:0] fp_res;
    logic [VEC_W-1:0] merged;
    logic [VEC_W-1:0] dst_q;
    logic             vld_q;

    vins_int_merge #(
        .VEC_W(VEC_W), .SCL_W(SCL_W), .LANE_W(8), .CTRL_W(CTRL_W)
    ) i_int (
        .clk(clk), .rst_n(rst_n),
        .size(elem_size_e'(in_size)), .ctrl(in_ctrl),
        .base(in_base), .scalar(in_scalar), .res(int_res)
    );

    vins_fp_merge #(
        .VEC_W(VEC_W), .ELEM_W(FP_W)
    ) i_fp (
        .clk(clk), .rst_n(rst_n),
        .from_mem(in_mem), .ctrl(in_ctrl),
        .base(in_base), .vec2(in_vec2), .scalar(in_scalar[FP_W-1:0]),
        .res(fp_res)
    );

    // Select the result of the requested mode.
    always_comb begin
        merged = in_fp ? fp_res : int_res;
    end

    // Output register: the strobe follows the input, and data loads on a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            dst_q <= '0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) dst_q <= merged;
        end
    end

    assign out_valid = vld_q;
    assign out_dst   = {{(OUT_W-VEC_W){1'b0}}, dst_q};

    // R10: the output strobe is the request strobe delayed by one clock.
    p_valid_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R10: the result holds while there is no request.
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_dst));

    // R8: a masked element is zero in the registered float result.
    for (genvar k = 0; k < NFP; k++) begin : g_zchk
        p_zero_lane_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_fp && in_ctrl[k]) |=> (out_dst[k*FP_W +: FP_W] == '0));
    end
endmodule

// File: tb/test_vec_insert_unit.sv
`timescale 1ns/1ps
module test_vec_insert_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_fp = 1'b0;
    logic         in_mem = 1'b0;
    logic [1:0]   in_size = 2'd0;
    logic [7:0]   in_ctrl = 8'd0;
    logic [127:0] in_base = '0;
    logic [127:0] in_vec2 = '0;
    logic [63:0]  in_scalar = '0;
    logic         out_valid;
    logic [255:0] out_dst;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    localparam logic [127:0] BASE = 128'h0f0e0d0c_0b0a0908_07060504_03020100;
    localparam logic [127:0] VEC2 = 128'hdddddddd_cccccccc_bbbbbbbb_aaaaaaaa;
    localparam logic [63:0]  SCL  = 64'h88776655_44332211;

    // Row layout: {tag[7:0], fp, mem, size[1:0], ctrl[7:0]}
    localparam int NROW = 18;
    localparam logic [19:0] ROWS [NROW] = '{
        {8'd1, 1'b0, 1'b0, 2'd0, 8'h05},  // R1 byte index 5
        {8'd1, 1'b0, 1'b0, 2'd0, 8'hFF},  // R1 index 15 after masking
        {8'd1, 1'b0, 1'b1, 2'd0, 8'h13},  // R1 masks to 3; R5 mem ignored
        {8'd2, 1'b0, 1'b0, 2'd1, 8'h0A},  // R2 masks to 2
        {8'd2, 1'b0, 1'b0, 2'd1, 8'h07},  // R2 top element
        {8'd3, 1'b0, 1'b0, 2'd2, 8'h06},  // R3 masks to 2
        {8'd3, 1'b0, 1'b0, 2'd2, 8'h00},  // R3 element 0
        {8'd4, 1'b0, 1'b0, 2'd3, 8'h03},  // R4 masks to 1
        {8'd4, 1'b0, 1'b0, 2'd3, 8'h02},  // R4 masks to 0
        {8'd6, 1'b1, 1'b0, 2'd0, 8'hB0},  // R6 src 2 to slot 3
        {8'd6, 1'b1, 1'b0, 2'd0, 8'h40},  // R6 src 1 to slot 0
        {8'd8, 1'b1, 1'b0, 2'd0, 8'hE5},  // R8 src 3 to slot 2, zero 0 and 2
        {8'd8, 1'b1, 1'b0, 2'd0, 8'h18},  // R8 zero element 3
        {8'd8, 1'b1, 1'b0, 2'd0, 8'h22},  // R8 zero element 1
        {8'd7, 1'b1, 1'b1, 2'd0, 8'hD0},  // R7 memory form, src field 3
        {8'd7, 1'b1, 1'b1, 2'd0, 8'h10},  // R7 same slot, src field 0
        {8'd8, 1'b1, 1'b0, 2'd0, 8'h24},  // R8 zeroes the slot just written
        {8'd8, 1'b1, 1'b0, 2'd0, 8'h0F}   // R8 all elements zeroed
    };

    vec_insert_unit i_vec_insert_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_fp(in_fp),
        .in_mem(in_mem), .in_size(in_size), .in_ctrl(in_ctrl),
        .in_base(in_base), .in_vec2(in_vec2), .in_scalar(in_scalar),
        .out_valid(out_valid), .out_dst(out_dst)
    );

    always #4 clk = ~clk;

    // Expected result, computed from the requirements.
    function automatic logic [127:0] expect_of(input logic fp, input logic mem,
            input logic [1:0] size, input logic [7:0] ctrl, input logic [127:0] b,
            input logic [127:0] v, input logic [63:0] s);
        logic [127:0] r;
        logic [31:0]  w;
        int idx;
        r = b;
        if (!fp) begin
            case (size)
                2'd0: begin idx = int'(ctrl & 8'h0F); r[idx*8  +: 8]  = s[7:0];  end
                2'd1: begin idx = int'(ctrl & 8'h07); r[idx*16 +: 16] = s[15:0]; end
                2'd2: begin idx = int'(ctrl & 8'h03); r[idx*32 +: 32] = s[31:0]; end
                default: begin idx = int'(ctrl & 8'h01); r[idx*64 +: 64] = s; end
            endcase
        end else begin
            w = mem ? s[31:0] : v[int'(ctrl[7:6])*32 +: 32];
            r[int'(ctrl[5:4])*32 +: 32] = w;
            for (int k = 0; k < 4; k++) if (ctrl[k]) r[k*32 +: 32] = '0;
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic fp, input logic mem, input logic [1:0] sz,
            input logic [7:0] c, input logic [127:0] b, input logic [127:0] v2, input logic [63:0] s);
        in_valid = v; in_fp = fp; in_mem = mem; in_size = sz;
        in_ctrl = c; in_base = b; in_vec2 = v2; in_scalar = s;
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [255:0] held;
        // R11: reset state, with a request presented while reset is low
        drive(1'b1, 1'b0, 1'b0, 2'd0, 8'h01, BASE, VEC2, SCL);
        repeat (3) @(negedge clk);
        check("R11 valid", {255'd0, out_valid}, 256'd0);
        check("R11 data", out_dst, 256'd0);
        drive(1'b0, 1'b0, 1'b0, 2'd0, 8'h00, BASE, VEC2, SCL);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk
        for (int i = 0; i < NROW; i++) begin
            logic [19:0] row;
            row = ROWS[i];
            drive(1'b1, row[11], row[10], row[9:8], row[7:0], BASE, VEC2, SCL);
            @(negedge clk);
            check($sformatf("R%0d row %0d", row[19:12], i), out_dst,
                  {128'd0, expect_of(row[11], row[10], row[9:8], row[7:0], BASE, VEC2, SCL)});
            check("R9 upper half", {128'd0, out_dst[255:128]}, 256'd0);
            check("R10 valid", {255'd0, out_valid}, {255'd0, 1'b1});
        end

        // R5: all-ones base, zero scalar, 32-bit element 1
        drive(1'b1, 1'b0, 1'b0, 2'd2, 8'h01, {128{1'b1}}, VEC2, 64'd0);
        @(negedge clk);
        check("R5 kept bits", out_dst,
              {128'd0, 128'hffffffff_ffffffff_00000000_ffffffff});

        // R8 hard value: insert then zero everything
        drive(1'b1, 1'b1, 1'b0, 2'd0, 8'h3F, BASE, VEC2, SCL);
        @(negedge clk);
        check("R8 full mask", out_dst, 256'd0);

        // R10: no request, so the output holds and the strobe drops
        drive(1'b1, 1'b1, 1'b0, 2'd0, 8'hB0, BASE, VEC2, SCL);
        @(negedge clk);
        held = out_dst;
        drive(1'b0, 1'b0, 1'b0, 2'd3, 8'h01, ~BASE, ~VEC2, ~SCL);
        @(negedge clk);
        check("R10 idle valid", {255'd0, out_valid}, 256'd0);
        check("R10 hold", out_dst, held);
        check("R6 held value", held, {128'd0, expect_of(1'b1, 1'b0, 2'd0, 8'hB0, BASE, VEC2, SCL)});
        @(negedge clk);
        check("R10 hold second cycle", out_dst, held);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule